// File: doc/BRIEF.md
# DMA Burst Command and Length Planner

This block sits inside a bus-mastering DMA engine and turns one transfer request (a double-word aligned byte address, a length in double words and a direction) into a series of bursts. For each burst it gives the bus command code and the number of double words to move. It picks between plain, line and multiple style commands from the cache-line size, from whether the burst starts on a line boundary, and from how much of a line the burst covers. It also limits every burst to a coded maximum length.

A transfer is loaded through a valid/ready start handshake. The configuration (line-size code, burst-length code and the three command enables) is captured at that moment. The planner then presents one burst at a time on a valid/ready output handshake. It advances its address and remaining count each time a burst is taken, and it returns to idle after the burst marked last. Bus signalling, the data path and arbitration belong to the neighbouring blocks.

Top module: `dma_burst_planner`

## Requirements
- R1: After reset `burst_valid` is 0 and `start_ready` is 1. The captured configuration resets to line code 00, burst code 16 and all command enables off.
- R2: A start is accepted only while idle (`start_ready`=1) and only with a nonzero length. A zero-length start, or a start offered while busy, produces no burst and changes nothing.
- R3: The burst-length code gives a cap in DW: 1, 2, 4, 8, 16 or 32 cap at that value, 0 means no cap, and any other code caps at 16.
- R4: Every burst is 1 DW or longer and never exceeds the remaining length. The burst lengths add up to the transfer length, each burst address is the previous one plus 4 bytes per DW moved, and `burst_last` is 1 exactly on the final burst.
- R5: For writes: if write-and-invalidate is enabled, a line size is set, the start address is line aligned and the capped length covers at least one line, the command is 1111 and the length is rounded down to whole lines. Otherwise the command is 0111 and the length is the capped length.
- R6: For reads: if read-multiple is enabled, a line size is set, the start is line aligned and the capped length covers at least one line, the command is 1100 and the length is rounded down to whole lines.
- R7: For reads: if read-line is enabled, a line size is set and the capped length reaches the next line boundary, the command is 1110 and the burst ends exactly at that boundary. A read that falls short of the boundary uses 0110 with the capped length.
- R8: When several read commands qualify, 1100 wins over 1110, and 1110 wins over 0110.
- R9: Line-size code 01 means 8 DW, 10 means 16 DW and 11 means 32 DW. Code 00 disables every line-based command, so only 0110 and 0111 appear.
- R10: While `burst_valid` is 1 and `burst_ready` is 0, command, length, address and last flag hold steady.
- R11: Configuration inputs that change after a start is accepted do not affect that transfer's bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Transfer request offered |
| start_ready | output | 1 | Planner idle and able to take a request |
| start_addr | input | ADDR_W | Byte address of the first DW (DW aligned) |
| start_len | input | LEN_W | Transfer length in DW |
| start_write | input | 1 | 1 for a write to memory, 0 for a read |
| cfg_line_code | input | 2 | Cache-line size code |
| cfg_burst_code | input | 6 | Maximum burst length code |
| cfg_wr_inv_en | input | 1 | Allow write-and-invalidate |
| cfg_rd_line_en | input | 1 | Allow read-line |
| cfg_rd_mult_en | input | 1 | Allow read-multiple |
| burst_valid | output | 1 | A burst is presented |
| burst_ready | input | 1 | Consumer takes the presented burst |
| burst_cmd | output | 4 | Bus command code |
| burst_addr | output | ADDR_W | Byte address of the burst |
| burst_len | output | LEN_W | Burst length in DW |
| burst_last | output | 1 | This burst completes the transfer |

## Verification
On every cycle the assertions check the structural rules: each burst is nonzero and fits in what remains, the last flag matches the remaining count, outputs hold while stalled, line commands only appear with line geometry (whole lines for the write-and-invalidate and read-multiple codes, a read-line burst ending on a boundary), and no line command appears with line code 00. Only the bench scenarios can show that the right command is picked when a rule allows more than one, that the cap decode and its fallback give the expected lengths, and that burst sequences and addresses come out exactly as worked out by hand. The same holds for ignored zero-length or busy-time starts and for configuration changes made mid-transfer.

// File: rtl/dma_plan_pkg.sv
// Shared command codes and configuration record for the DMA burst planner.
// Assumes the consumer decodes the four-bit command values listed here.
package dma_plan_pkg;

    typedef enum logic [3:0] {
        CMD_MEM_RD  = 4'b0110,
        CMD_MEM_WR  = 4'b0111,
        CMD_RD_MULT = 4'b1100,
        CMD_RD_LINE = 4'b1110,
        CMD_WR_INV  = 4'b1111
    } bus_cmd_e;

    typedef struct packed {
        logic [1:0] line_code;
        logic [5:0] burst_code;
        logic       wr_inv_en;
        logic       rd_line_en;
        logic       rd_mult_en;
    } plan_cfg_t;

    localparam plan_cfg_t CFG_RESET = '{
        line_code:  2'b00,
        burst_code: 6'd16,
        wr_inv_en:  1'b0,
        rd_line_en: 1'b0,
        rd_mult_en: 1'b0
    };

endpackage

// File: rtl/line_size_decode.sv
// Turns the two-bit cache-line code into a line size in DW.
// Assumes code 00 means no line handling; line_dw is then zero.
module line_size_decode #(
    parameter int LEN_W = 16
) (
    input  logic [1:0]       code,
    output logic [LEN_W-1:0] line_dw,
    output logic             line_on
);
    // decode the code to a power-of-two size
    always_comb begin
        unique case (code)
            2'b01:   line_dw = LEN_W'(8);
            2'b10:   line_dw = LEN_W'(16);
            2'b11:   line_dw = LEN_W'(32);
            default: line_dw = '0;
        endcase
        line_on = (code != 2'b00);
    end
endmodule

// File: rtl/burst_cap_decode.sv
// Turns the six-bit burst-length code into a cap in DW.
// Assumes 0 means unlimited; unsupported codes fall back to 16.
module burst_cap_decode #(
    parameter int LEN_W = 16
) (
    input  logic [5:0]       code,
    output logic [LEN_W-1:0] cap_dw,
    output logic             unlimited
);
    // map legal codes, substitute 16 for the rest
    always_comb begin
        unlimited = 1'b0;
        unique case (code)
            6'd0:    begin cap_dw = '0; unlimited = 1'b1; end
            6'd1:    cap_dw = LEN_W'(1);
            6'd2:    cap_dw = LEN_W'(2);
            6'd4:    cap_dw = LEN_W'(4);
            6'd8:    cap_dw = LEN_W'(8);
            6'd32:   cap_dw = LEN_W'(32);
            default: cap_dw = LEN_W'(16);
        endcase
    end
endmodule

// File: rtl/burst_select.sv
// Combinational choice of command and length for the burst at cur_addr.
// Assumes cur_addr is DW aligned and remaining is nonzero while used.
module burst_select
    import dma_plan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remaining,
    input  logic              is_write,
    input  plan_cfg_t         cfg,
    output bus_cmd_e          cmd,
    output logic [LEN_W-1:0]  len
);
    logic [LEN_W-1:0] line_dw, cap_dw, line_mask, offset, to_bound, base, whole;
    logic             line_on, unlimited, aligned, covers, reaches;

    line_size_decode #(.LEN_W(LEN_W)) u_line (
        .code(cfg.line_code), .line_dw(line_dw), .line_on(line_on)
    );

    burst_cap_decode #(.LEN_W(LEN_W)) u_cap (
        .code(cfg.burst_code), .cap_dw(cap_dw), .unlimited(unlimited)
    );

    // geometry of the current position within its cache line
    always_comb begin
        line_mask = line_dw - LEN_W'(1);
        offset    = LEN_W'(cur_addr[6:2]) & line_mask;
        to_bound  = line_dw - offset;
        base      = (!unlimited && cap_dw < remaining) ? cap_dw : remaining;
        whole     = base & ~line_mask;
        aligned   = (offset == '0);
        covers    = line_on && aligned && (base >= line_dw);
        reaches   = line_on && (base >= to_bound);
    end

    // pick the command by priority and size the burst to match
    always_comb begin
        cmd = is_write ? CMD_MEM_WR : CMD_MEM_RD;
        len = base;
        if (is_write) begin
            if (cfg.wr_inv_en && covers) begin
                cmd = CMD_WR_INV;
                len = whole;
            end
        end else if (cfg.rd_mult_en && covers) begin
            cmd = CMD_RD_MULT;
            len = whole;
        end else if (cfg.rd_line_en && reaches) begin
            cmd = CMD_RD_LINE;
            len = to_bound;
        end
    end
endmodule

// File: rtl/dma_burst_planner.sv
// Top: accepts a transfer, captures its configuration, then walks it burst
// by burst over a valid/ready handshake. Assumes DW-aligned start addresses.
module dma_burst_planner
    import dma_plan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              start_write,
    input  logic [1:0]        cfg_line_code,
    input  logic [5:0]        cfg_burst_code,
    input  logic              cfg_wr_inv_en,
    input  logic              cfg_rd_line_en,
    input  logic              cfg_rd_mult_en,
    output logic              burst_valid,
    input  logic              burst_ready,
    output logic [3:0]        burst_cmd,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [LEN_W-1:0]  burst_len,
    output logic              burst_last
);
    logic              busy_q, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    plan_cfg_t         cfg_q;
    bus_cmd_e          sel_cmd;
    logic [LEN_W-1:0]  sel_len;
    logic              accept, fire;

    burst_select #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_sel (
        .cur_addr(addr_q), .remaining(rem_q), .is_write(wr_q),
        .cfg(cfg_q), .cmd(sel_cmd), .len(sel_len)
    );

    // handshake decode and output view of the current burst
    always_comb begin
        start_ready = !busy_q;
        accept      = start_valid && !busy_q && (start_len != '0);
        burst_valid = busy_q;
        fire        = busy_q && burst_ready;
        burst_cmd   = sel_cmd;
        burst_len   = sel_len;
        burst_addr  = addr_q;
        burst_last  = (sel_len == rem_q);
    end

    // transfer state: load on start, advance on each taken burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            cfg_q  <= CFG_RESET;
        end else if (accept) begin
            busy_q <= 1'b1;
            wr_q   <= start_write;
            addr_q <= start_addr;
            rem_q  <= start_len;
            cfg_q  <= '{line_code: cfg_line_code, burst_code: cfg_burst_code,
                        wr_inv_en: cfg_wr_inv_en, rd_line_en: cfg_rd_line_en,
                        rd_mult_en: cfg_rd_mult_en};
        end else if (fire) begin
            addr_q <= addr_q + ADDR_W'({sel_len, 2'b00});
            rem_q  <= rem_q - sel_len;
            if (burst_last) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_burst_planner_chk.sv
// Checker for dma_burst_planner: tracks the transfer from the ports and
// checks burst geometry and handshake rules every cycle.
module dma_burst_planner_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic [LEN_W-1:0]  start_len,
    input logic              start_write,
    input logic [1:0]        cfg_line_code,
    input logic              burst_valid,
    input logic              burst_ready,
    input logic [3:0]        burst_cmd,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [LEN_W-1:0]  burst_len,
    input logic              burst_last
);
    logic [LEN_W-1:0] c_rem, c_line, c_mask;
    logic [1:0]       c_code;
    logic             c_wr;

    // shadow the remaining count and captured line code from port traffic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_rem <= '0; c_code <= 2'b00; c_wr <= 1'b0;
        end else if (start_valid && start_ready && start_len != '0) begin
            c_rem <= start_len; c_code <= cfg_line_code; c_wr <= start_write;
        end else if (burst_valid && burst_ready) begin
            c_rem <= c_rem - burst_len;
        end
    end

    // line size seen by the checker
    always_comb begin
        c_line = LEN_W'(8) << c_code;
        c_line = (c_code == 2'b00) ? '0 : (c_line >> 1);
        c_mask = c_line - LEN_W'(1);
    end

    a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != '0) && (burst_len <= c_rem));
    a_r4_last_flag: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_last == (burst_len == c_rem)));
    a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_ready && burst_last |=> !burst_valid);
    a_r2_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> !start_ready);
    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && !burst_ready |=> burst_valid && $stable(burst_cmd)
            && $stable(burst_len) && $stable(burst_addr) && $stable(burst_last));
    a_r5_wr_inv_whole_lines: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_cmd == 4'b1111 |-> c_wr && (c_code != 2'b00)
            && ((LEN_W'(burst_addr[6:2]) & c_mask) == '0) && ((burst_len & c_mask) == '0));
    a_r6_rd_mult_whole_lines: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_cmd == 4'b1100 |-> !c_wr && (c_code != 2'b00)
            && ((LEN_W'(burst_addr[6:2]) & c_mask) == '0) && ((burst_len & c_mask) == '0));
    a_r7_rd_line_to_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_cmd == 4'b1110 |-> !c_wr && (c_code != 2'b00)
            && (((LEN_W'(burst_addr[6:2]) + burst_len) & c_mask) == '0));
    a_r9_plain_without_line: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && c_code == 2'b00 |-> (burst_cmd == 4'b0110 || burst_cmd == 4'b0111));
endmodule

bind dma_burst_planner dma_burst_planner_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_len(start_len), .start_write(start_write), .cfg_line_code(cfg_line_code),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_cmd(burst_cmd),
    .burst_addr(burst_addr), .burst_len(burst_len), .burst_last(burst_last)
);

// File: tb/dma_burst_planner_bench.sv
// Directed bench: one task per scenario, expected bursts worked out by hand.
module dma_burst_planner_bench;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0, start_write = 1'b0, burst_ready = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] start_len = '0;
    logic [1:0]    cfg_line_code = 2'b00;
    logic [5:0]    cfg_burst_code = 6'd16;
    logic          cfg_wr_inv_en = 1'b0, cfg_rd_line_en = 1'b0, cfg_rd_mult_en = 1'b0;
    logic          start_ready, burst_valid, burst_last;
    logic [3:0]    burst_cmd;
    logic [AW-1:0] burst_addr;
    logic [LW-1:0] burst_len;
    int            checks = 0, errors = 0;

    always #10 clk = ~clk;

    dma_burst_planner #(.ADDR_W(AW), .LEN_W(LW)) u_dma_burst_planner (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .start_len(start_len), .start_write(start_write),
        .cfg_line_code(cfg_line_code), .cfg_burst_code(cfg_burst_code),
        .cfg_wr_inv_en(cfg_wr_inv_en), .cfg_rd_line_en(cfg_rd_line_en),
        .cfg_rd_mult_en(cfg_rd_mult_en), .burst_valid(burst_valid),
        .burst_ready(burst_ready), .burst_cmd(burst_cmd), .burst_addr(burst_addr),
        .burst_len(burst_len), .burst_last(burst_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] lc, input logic [5:0] bc,
                           input logic wi, input logic rl, input logic rm);
        cfg_line_code = lc; cfg_burst_code = bc;
        cfg_wr_inv_en = wi; cfg_rd_line_en = rl; cfg_rd_mult_en = rm;
    endtask

    task automatic start(input logic [AW-1:0] a, input logic [LW-1:0] n, input logic wr);
        @(negedge clk);
        start_valid = 1'b1; start_addr = a; start_len = n; start_write = wr;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    // check one presented burst, then take it
    task automatic expect_burst(input string req, input logic [3:0] cmd,
                                input logic [LW-1:0] len, input logic [AW-1:0] a,
                                input logic last);
        for (int g = 0; g < 10 && !burst_valid; g++) @(negedge clk);
        check(burst_valid == 1'b1, req, "burst_valid", 32'(burst_valid), 32'd1);
        check(burst_cmd == cmd, req, "burst_cmd", 32'(burst_cmd), 32'(cmd));
        check(burst_len == len, req, "burst_len", 32'(burst_len), 32'(len));
        check(burst_addr == a, req, "burst_addr", burst_addr, a);
        check(burst_last == last, req, "burst_last", 32'(burst_last), 32'(last));
        burst_ready = 1'b1;
        @(negedge clk);
        burst_ready = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        check(burst_valid == 1'b0, req, "idle burst_valid", 32'(burst_valid), 32'd0);
        check(start_ready == 1'b1, req, "idle start_ready", 32'(start_ready), 32'd1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_idle("R1");
    endtask

    task automatic t_plain_read;
        set_cfg(2'b00, 6'd16, 1'b0, 1'b0, 1'b0);
        start(32'h1000, 16'd40, 1'b0);
        expect_burst("R4", 4'b0110, 16'd16, 32'h1000, 1'b0);
        expect_burst("R4", 4'b0110, 16'd16, 32'h1040, 1'b0);
        expect_burst("R4", 4'b0110, 16'd8,  32'h1080, 1'b1);
        expect_idle("R4");
    endtask

    task automatic t_caps;
        set_cfg(2'b00, 6'd0, 1'b0, 1'b0, 1'b0);
        start(32'h100, 16'd40, 1'b0);
        expect_burst("R3 unlimited", 4'b0110, 16'd40, 32'h100, 1'b1);
        set_cfg(2'b00, 6'd5, 1'b0, 1'b0, 1'b0);
        start(32'h200, 16'd20, 1'b1);
        expect_burst("R3 fallback", 4'b0111, 16'd16, 32'h200, 1'b0);
        expect_burst("R3 fallback", 4'b0111, 16'd4,  32'h240, 1'b1);
        set_cfg(2'b00, 6'd1, 1'b0, 1'b0, 1'b0);
        start(32'h300, 16'd3, 1'b0);
        expect_burst("R3 cap1", 4'b0110, 16'd1, 32'h300, 1'b0);
        expect_burst("R3 cap1", 4'b0110, 16'd1, 32'h304, 1'b0);
        expect_burst("R3 cap1", 4'b0110, 16'd1, 32'h308, 1'b1);
    endtask

    task automatic t_write_inv;
        set_cfg(2'b01, 6'd16, 1'b1, 1'b0, 1'b0);
        start(32'h2000, 16'd20, 1'b1);
        expect_burst("R5", 4'b1111, 16'd16, 32'h2000, 1'b0);
        expect_burst("R5", 4'b0111, 16'd4,  32'h2040, 1'b1);
        start(32'h2004, 16'd16, 1'b1);
        expect_burst("R5 unaligned", 4'b0111, 16'd16, 32'h2004, 1'b1);
        set_cfg(2'b01, 6'd16, 1'b0, 1'b1, 1'b1);
        start(32'h2000, 16'd8, 1'b1);
        expect_burst("R5 disabled", 4'b0111, 16'd8, 32'h2000, 1'b1);
    endtask

    task automatic t_read_mult;
        set_cfg(2'b10, 6'd32, 1'b0, 1'b0, 1'b1);
        start(32'h3000, 16'd40, 1'b0);
        expect_burst("R6", 4'b1100, 16'd32, 32'h3000, 1'b0);
        expect_burst("R6", 4'b0110, 16'd8,  32'h3080, 1'b1);
    endtask

    task automatic t_read_line;
        set_cfg(2'b01, 6'd16, 1'b0, 1'b1, 1'b0);
        start(32'h4008, 16'd30, 1'b0);
        expect_burst("R7", 4'b1110, 16'd6, 32'h4008, 1'b0);
        expect_burst("R7", 4'b1110, 16'd8, 32'h4020, 1'b0);
        expect_burst("R7", 4'b1110, 16'd8, 32'h4040, 1'b0);
        expect_burst("R7", 4'b1110, 16'd8, 32'h4060, 1'b1);
        start(32'h4008, 16'd3, 1'b0);
        expect_burst("R7 short", 4'b0110, 16'd3, 32'h4008, 1'b1);
    endtask

    task automatic t_priority;
        set_cfg(2'b01, 6'd16, 1'b0, 1'b1, 1'b1);
        start(32'h5000, 16'd20, 1'b0);
        expect_burst("R8", 4'b1100, 16'd16, 32'h5000, 1'b0);
        expect_burst("R8", 4'b0110, 16'd4,  32'h5040, 1'b1);
        start(32'h5010, 16'd12, 1'b0);
        expect_burst("R8", 4'b1110, 16'd4, 32'h5010, 1'b0);
        expect_burst("R8", 4'b1100, 16'd8, 32'h5020, 1'b1);
    endtask

    task automatic t_no_line;
        set_cfg(2'b00, 6'd16, 1'b1, 1'b1, 1'b1);
        start(32'h6000, 16'd16, 1'b1);
        expect_burst("R9", 4'b0111, 16'd16, 32'h6000, 1'b1);
        start(32'h6000, 16'd16, 1'b0);
        expect_burst("R9", 4'b0110, 16'd16, 32'h6000, 1'b1);
    endtask

    task automatic t_stall;
        set_cfg(2'b00, 6'd16, 1'b0, 1'b0, 1'b0);
        start(32'h7000, 16'd4, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(burst_valid && burst_cmd == 4'b0110 && burst_len == 16'd4
                  && burst_addr == 32'h7000 && burst_last, "R10", "stalled burst",
                  burst_addr, 32'h7000);
        end
        expect_burst("R10", 4'b0110, 16'd4, 32'h7000, 1'b1);
    endtask

    task automatic t_zero_len;
        start(32'h8000, 16'd0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            expect_idle("R2 zero length");
            @(negedge clk);
        end
    endtask

    task automatic t_midway_change;
        set_cfg(2'b00, 6'd16, 1'b0, 1'b0, 1'b0);
        start(32'h9000, 16'd32, 1'b0);
        set_cfg(2'b01, 6'd1, 1'b0, 1'b1, 1'b1);
        check(start_ready == 1'b0, "R2 busy", "start_ready", 32'(start_ready), 32'd0);
        start_valid = 1'b1; start_addr = 32'hA000; start_len = 16'd2;
        @(negedge clk);
        start_valid = 1'b0;
        expect_burst("R11", 4'b0110, 16'd16, 32'h9000, 1'b0);
        expect_burst("R11", 4'b0110, 16'd16, 32'h9040, 1'b1);
        expect_idle("R2 busy start dropped");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_read();
        t_caps();
        t_write_inv();
        t_read_mult();
        t_read_line();
        t_priority();
        t_no_line();
        t_stall();
        t_zero_len();
        t_midway_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule